// File: doc/BRIEF.md
# Programmable Serial Frame Transmitter

This block turns parallel words into a bit stream on a single transmit data line. Each frame is laid out the same way. A start event opens the frame. A frame-sync field may follow, then a start-delay gap, then a programmed number of data words of programmed length. Idle fill at the default level closes the frame. All frame fields are parameters of the frame and are taken from configuration inputs. A separate frame-sync output pulses for the length of the sync field.

The block advances one bit per cycle in which the bit-clock enable is high. Bit-clock generation and start-event selection are outside it. Data words arrive on a valid/ready handshake. The ready output pulses in the bit cycle where a word's first bit goes out, and the word moves across when valid is also high. If no word is offered at that point, the previous word is sent again and a sticky underrun flag is raised. In periodic mode the block restarts a frame by itself every 2*(period+1) bit cycles, for as long as periodic mode stays selected.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, td, fsync, tx_ready and underrun are all 0.
- R2: While no frame is active, every bit-clock edge loads td with cfg_dflt and fsync with 0.
- R3: A start event sampled on a bit-clock edge opens a frame. Frame bit 0 appears on td at the next bit-clock edge. fsync is 1 for the first {cfg_sync_ext,cfg_sync_len}+1 frame bits, which allows 1 to 256 bits.
- R4: Within the sync field, with cfg_sync_en=1, frame bit k for k<32 is sync_word[k], sent least significant bit first. With cfg_sync_en=0, every sync bit is cfg_dflt.
- R5: With cfg_sync_en=1, sync bits 32 to 63 are cfg_dflt. Sync bits 64 and later are tx_data[k mod 32] of the word currently held on tx_data, and that word is not consumed.
- R6: Data starts at frame bit cfg_start_dly. If the delay is longer than the sync field, the bits in between are cfg_dflt. If it is shorter, td switches to data at bit cfg_start_dly while fsync still runs its full length.
- R7: A frame carries cfg_word_cnt+1 words of cfg_word_len+1 bits each. tx_ready is 1 in the bit cycle that sends a word's first bit, and the word transfers when tx_valid is also 1. After the last data bit, td is cfg_dflt until the frame ends.
- R8: With cfg_msb_first=1 each word is sent from bit cfg_word_len down to bit 0. With cfg_msb_first=0 it is sent from bit 0 upward.
- R9: With cfg_periodic=1, a frame lasts 2*(cfg_period+1) bit cycles and the next frame follows at once. Data still pending at the frame end is dropped. A non-periodic frame ends after max(sync length, start delay + data bits) bits.
- R10: If tx_valid is 0 when tx_ready is 1, the previous word is sent again and underrun is set. underrun stays set until reset.
- R11: Configuration inputs and sync_word are captured when a frame opens. Changing them during a frame does not alter that frame.
- R12: td and fsync change only on clock edges where bit_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one frame bit per high cycle |
| start_evt | input | 1 | Frame start request, qualified by bit_en |
| cfg_start_dly | input | 8 | Bits from frame start to first data bit |
| cfg_word_len | input | 5 | Word length minus one |
| cfg_word_cnt | input | 4 | Words per frame minus one |
| cfg_sync_len | input | 4 | Sync length base (low part of length minus one) |
| cfg_sync_ext | input | 4 | Sync length extension (counts 16 bits each) |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_sync_en | input | 1 | 1: sync field carries sync_word data |
| cfg_dflt | input | 1 | Default line level |
| cfg_periodic | input | 1 | 1: restart frames automatically |
| cfg_period | input | 8 | Periodic frame length is 2*(value+1) bits |
| sync_word | input | 32 | Sync holding word |
| tx_data | input | 32 | Data holding word |
| tx_valid | input | 1 | Data holding word is valid |
| tx_ready | output | 1 | Word wanted this bit cycle |
| td | output | 1 | Serial transmit data |
| fsync | output | 1 | Frame-sync pulse |
| underrun | output | 1 | Sticky flag for a missing data word |

## Verification
Frames are checked bit by bit against a model of the requirements. The tests cover the following cases. A delay longer than a short sync field, with MSB-first data and a known sync word, separates the gap fill from sync and data. A delay shorter than the sync field, with sync data disabled and LSB-first words, exposes truncation and bit order. An 80-bit sync field shows the sync-word, default-level and holding-word segments in turn. A starved word queue shows the resend and the sticky flag. Periodic frames show the restart point and the trailing fill. Further tests change the configuration in mid-frame and slow the bit-clock enable, which shows that configuration is captured per frame and that the outputs hold between enabled edges.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        start_evt,
  input  logic [7:0]  cfg_start_dly,
  input  logic [4:0]  cfg_word_len,
  input  logic [3:0]  cfg_word_cnt,
  input  logic [3:0]  cfg_sync_len,
  input  logic [3:0]  cfg_sync_ext,
  input  logic        cfg_msb_first,
  input  logic        cfg_sync_en,
  input  logic        cfg_dflt,
  input  logic        cfg_periodic,
  input  logic [7:0]  cfg_period,
  input  logic [31:0] sync_word,
  input  logic [31:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        td,
  output logic        fsync,
  output logic        underrun
);

  logic        active, done;
  logic [9:0]  k;
  logic [4:0]  j;
  logic [3:0]  w;
  logic [31:0] cur;

  logic [7:0]  stt_q, sl_q, period_q;
  logic [4:0]  wl_q;
  logic [3:0]  wc_q;
  logic        msb_q, sen_q, dflt_q, per_q;
  logic [31:0] sync_q;

  logic [9:0]  syncl, stt_x, total, data_end, nonper_len, per_len, flen;
  logic        in_sync, pre_data, data_now, last, load_cfg, take;
  logic        sync_bit, data_bit, next_td;
  logic [4:0]  bidx;
  logic [31:0] word_now;

  assign syncl      = 10'(sl_q) + 10'd1;
  assign stt_x      = 10'(stt_q);
  assign total      = (10'(wc_q) + 10'd1) * (10'(wl_q) + 10'd1);
  assign data_end   = stt_x + total;
  assign nonper_len = (syncl > data_end) ? syncl : data_end;
  assign per_len    = {1'b0, period_q, 1'b0} + 10'd2;
  assign flen       = per_q ? per_len : nonper_len;
  assign last       = (k == flen - 10'd1);

  assign in_sync  = k < syncl;
  assign pre_data = k < stt_x;
  assign data_now = active && !pre_data && !done;

  assign tx_ready = bit_en && data_now && (j == 5'd0);
  assign take     = tx_ready && tx_valid;
  assign word_now = (j == 5'd0) ? (take ? tx_data : cur) : cur;
  assign bidx     = msb_q ? (wl_q - j) : j;
  assign data_bit = word_now[bidx];

  always_comb begin
    if (!sen_q)               sync_bit = dflt_q;
    else if (k[9:5] == 5'd0)  sync_bit = sync_q[k[4:0]];
    else if (k[9:6] == 4'd0)  sync_bit = dflt_q;
    else                      sync_bit = tx_data[k[4:0]];
  end

  assign next_td  = pre_data ? (in_sync ? sync_bit : dflt_q)
                             : (done ? dflt_q : data_bit);

  assign load_cfg = bit_en && (active ? (last && per_q && cfg_periodic) : start_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stt_q <= '0; sl_q <= '0; period_q <= '0; wl_q <= '0; wc_q <= '0;
      msb_q <= 1'b0; sen_q <= 1'b0; dflt_q <= 1'b0; per_q <= 1'b0; sync_q <= '0;
    end else if (load_cfg) begin
      stt_q    <= cfg_start_dly;
      sl_q     <= {cfg_sync_ext, cfg_sync_len};
      period_q <= cfg_period;
      wl_q     <= cfg_word_len;
      wc_q     <= cfg_word_cnt;
      msb_q    <= cfg_msb_first;
      sen_q    <= cfg_sync_en;
      dflt_q   <= cfg_dflt;
      per_q    <= cfg_periodic;
      sync_q   <= sync_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0; k <= '0; j <= '0; w <= '0; cur <= '0;
      td <= 1'b0; fsync <= 1'b0; underrun <= 1'b0;
    end else if (bit_en) begin
      if (!active) begin
        td    <= cfg_dflt;
        fsync <= 1'b0;
      end else begin
        td    <= next_td;
        fsync <= in_sync;
      end
      if (tx_ready && !tx_valid) underrun <= 1'b1;
      if (data_now && j == 5'd0) cur <= word_now;
      if (load_cfg) begin
        active <= 1'b1;
        k <= '0; j <= '0; w <= '0; done <= 1'b0;
      end else if (active) begin
        if (last) active <= 1'b0;
        else      k <= k + 10'd1;
        if (data_now) begin
          if (j == wl_q) begin
            j <= '0;
            if (w == wc_q) done <= 1'b1;
            else           w <= w + 4'd1;
          end else begin
            j <= j + 5'd1;
          end
        end
      end
    end
  end

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !active) |=> (td == $past(cfg_dflt) && !fsync));

  // R12
  hold_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(td) && $stable(fsync)));

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R10
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> underrun);

  // R3
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !active && start_evt) |=> (active && k == 10'd0));

endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, start_evt = 1'b0;
  logic [7:0] c_stt = '0, c_P = '0;
  logic [4:0] c_wl = '0;
  logic [3:0] c_wc = '0, c_sb = '0, c_se = '0;
  logic c_msb = 1'b0, c_sen = 1'b0, c_dflt = 1'b0, c_per = 1'b0;
  logic [31:0] c_sync = '0, tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, td, fsync, underrun;

  int checks = 0, failures = 0;
  logic [31:0] words [0:15];
  int nw = 0, idx = 0, exp_taken = 0;
  logic exp_td [0:1023];
  logic exp_fs [0:1023];
  logic [31:0] m_cur = '0;

  always #10 clk = ~clk;

  serial_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_evt(start_evt),
    .cfg_start_dly(c_stt), .cfg_word_len(c_wl), .cfg_word_cnt(c_wc),
    .cfg_sync_len(c_sb), .cfg_sync_ext(c_se), .cfg_msb_first(c_msb),
    .cfg_sync_en(c_sen), .cfg_dflt(c_dflt), .cfg_periodic(c_per),
    .cfg_period(c_P), .sync_word(c_sync), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .td(td), .fsync(fsync),
    .underrun(underrun));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_exp(int n);
    int syncl, total, fl, kk, j, w, im, bidx;
    logic done, b;
    logic [31:0] hold;
    syncl = int'(c_sb) + 16 * int'(c_se) + 1;
    total = (int'(c_wc) + 1) * (int'(c_wl) + 1);
    fl = c_per ? 2 * (int'(c_P) + 1)
               : ((syncl > int'(c_stt) + total) ? syncl : int'(c_stt) + total);
    kk = 0; j = 0; w = 0; im = 0; done = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!c_per && kk >= fl) begin
        exp_td[i] = c_dflt; exp_fs[i] = 1'b0;
      end else begin
        hold = (im < nw) ? words[im] : 32'h0;
        exp_fs[i] = (kk < syncl);
        if (kk < int'(c_stt)) begin
          if (kk < syncl) begin
            if (!c_sen)       b = c_dflt;
            else if (kk < 32) b = c_sync[kk];
            else if (kk < 64) b = c_dflt;
            else              b = hold[kk % 32];
          end else b = c_dflt;
        end else if (done) begin
          b = c_dflt;
        end else begin
          if (j == 0 && im < nw) begin m_cur = words[im]; im++; end
          bidx = c_msb ? int'(c_wl) - j : j;
          b = m_cur[bidx];
          if (j == int'(c_wl)) begin
            j = 0;
            if (w == int'(c_wc)) done = 1'b1; else w++;
          end else j++;
        end
        exp_td[i] = b;
        kk++;
        if (c_per && kk == fl) begin kk = 0; j = 0; w = 0; done = 1'b0; end
      end
    end
    exp_taken = im;
  endtask

  task automatic load_words(int n);
    nw = n; idx = 0;
    tx_valid = (n > 0);
    tx_data = (n > 0) ? words[0] : 32'h0;
  endtask

  task automatic run_frame(string tag, int n, int div, bit flip);
    logic fire;
    @(negedge clk);
    bit_en = 1'b1; start_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_evt = 1'b0;
    if (flip) begin c_msb = ~c_msb; c_dflt = ~c_dflt; c_stt = 8'd0; c_wc = 4'd0; c_sync = ~c_sync; end
    if (div > 1) begin
      bit_en = 1'b0;
      repeat (div - 1) begin @(posedge clk); @(negedge clk); end
    end
    for (int i = 0; i < n; i++) begin
      bit_en = 1'b1;
      #1;
      fire = tx_ready && tx_valid;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("%s td bit %0d", tag, i), {31'b0, td}, {31'b0, exp_td[i]});
      check($sformatf("%s fsync bit %0d", tag, i), {31'b0, fsync}, {31'b0, exp_fs[i]});
      if (fire) begin
        idx++;
        tx_valid = (idx < nw);
        tx_data = (idx < nw) ? words[idx] : 32'h0;
      end
      if (div > 1) begin
        bit_en = 1'b0;
        repeat (div - 1) begin
          @(posedge clk); @(negedge clk);
          // R12: outputs hold between enabled edges
          check($sformatf("R12 hold td bit %0d", i), {31'b0, td}, {31'b0, exp_td[i]});
          check($sformatf("R12 hold fsync bit %0d", i), {31'b0, fsync}, {31'b0, exp_fs[i]});
        end
      end
    end
    check({tag, " words taken (R7)"}, idx, exp_taken);
  endtask

  task automatic t_reset();
    // R1
    check("R1 td", {31'b0, td}, 0);
    check("R1 fsync", {31'b0, fsync}, 0);
    check("R1 tx_ready", {31'b0, tx_ready}, 0);
    check("R1 underrun", {31'b0, underrun}, 0);
    // R2: idle follows default level
    @(negedge clk); c_dflt = 1'b1; bit_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 idle td high", {31'b0, td}, 1);
    c_dflt = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 idle td low", {31'b0, td}, 0);
    check("R2 idle fsync", {31'b0, fsync}, 0);
  endtask

  task automatic t_msb_gap();
    c_sb = 4'd3; c_se = 4'd0; c_stt = 8'd6; c_wl = 5'd7; c_wc = 4'd1;
    c_msb = 1'b1; c_sen = 1'b1; c_dflt = 1'b1; c_per = 1'b0; c_sync = 32'h0000_00B6;
    words[0] = 32'h0000_00A3; words[1] = 32'h0000_005C;
    load_words(2);
    build_exp(26);
    run_frame("R3 R4 R6 R7 R8 msb gap", 26, 1, 1'b0);
  endtask

  task automatic t_lsb_trunc(int div);
    c_sb = 4'd9; c_se = 4'd0; c_stt = 8'd3; c_wl = 5'd4; c_wc = 4'd2;
    c_msb = 1'b0; c_sen = 1'b0; c_dflt = 1'b0; c_per = 1'b0; c_sync = 32'hFFFF_FFFF;
    words[0] = 32'h13; words[1] = 32'h0A; words[2] = 32'h1F;
    load_words(3);
    build_exp(22);
    run_frame(div > 1 ? "R12 slow enable" : "R4 R6 R8 lsb truncated", 22, div, 1'b0);
  endtask

  task automatic t_long_sync();
    c_sb = 4'd15; c_se = 4'd4; c_stt = 8'd90; c_wl = 5'd3; c_wc = 4'd0;
    c_msb = 1'b1; c_sen = 1'b1; c_dflt = 1'b0; c_per = 1'b0; c_sync = 32'hDEAD_BEEF;
    words[0] = 32'hC3A5_5A69;
    load_words(1);
    build_exp(98);
    run_frame("R5 long sync", 98, 1, 1'b0);
    // R10: no underrun so far
    check("R10 no false underrun", {31'b0, underrun}, 0);
  endtask

  task automatic t_underrun();
    c_sb = 4'd0; c_se = 4'd0; c_stt = 8'd1; c_wl = 5'd3; c_wc = 4'd2;
    c_msb = 1'b0; c_sen = 1'b1; c_dflt = 1'b1; c_per = 1'b0; c_sync = 32'h0;
    words[0] = 32'h6;
    load_words(1);
    build_exp(16);
    run_frame("R10 underrun resend", 16, 1, 1'b0);
    check("R10 underrun flag", {31'b0, underrun}, 1);
  endtask

  task automatic t_periodic();
    c_sb = 4'd1; c_se = 4'd0; c_stt = 8'd2; c_wl = 5'd7; c_wc = 4'd1;
    c_msb = 1'b1; c_sen = 1'b1; c_dflt = 1'b1; c_per = 1'b1; c_P = 8'd15; c_sync = 32'h2;
    words[0] = 32'h81; words[1] = 32'h7E; words[2] = 32'hC4; words[3] = 32'h3B;
    load_words(4);
    build_exp(70);
    run_frame("R9 periodic", 70, 1, 1'b0);
    c_per = 1'b0;
    repeat (80) @(negedge clk);
    check("R10 underrun remains set", {31'b0, underrun}, 1);
  endtask

  task automatic t_cfg_change();
    c_sb = 4'd3; c_se = 4'd0; c_stt = 8'd6; c_wl = 5'd7; c_wc = 4'd1;
    c_msb = 1'b1; c_sen = 1'b1; c_dflt = 1'b1; c_per = 1'b0; c_sync = 32'h0000_0049;
    words[0] = 32'h0000_00D2; words[1] = 32'h0000_0017;
    load_words(2);
    build_exp(22);
    run_frame("R11 config held", 22, 1, 1'b1);
    @(posedge clk); @(negedge clk);
    // R2: new default level shows once idle
    check("R2 idle after frame", {31'b0, td}, {31'b0, c_dflt});
    c_stt = 8'd6; c_wc = 4'd1;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
  end

  task automatic t_reset_pre();
    t_reset_before_release();
    rst_n = 1'b1;
    t_reset();
    t_msb_gap();
    t_lsb_trunc(1);
    t_long_sync();
    t_cfg_change();
    t_lsb_trunc(3);
    t_underrun();
    t_periodic();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic t_reset_before_release();
    check("R1 td in reset", {31'b0, td}, 0);
    check("R1 underrun in reset", {31'b0, underrun}, 0);
  endtask
endmodule